// File: doc/BRIEF.md
# Masked VLIW Instruction Expander

This block rebuilds a full 1024-bit very long instruction word from its compressed form in memory. The compressed form leaves out operation slots that carry nothing. Each instruction starts with a 32-bit occupancy mask, one bit per 32-bit operation slot. After the mask come only the fields of the occupied slots, packed back to back. The expander reads these 32-bit beats from a valid/ready stream. It places each packed field into its fixed slot and fills every unoccupied slot with the all-zero no-op. It then presents the finished word on a 1024-bit valid/ready output.

The block sits between the instruction fetch stream and the issue stage. While a finished word waits for the consumer, the block stops taking input. This gives back-pressure from the issue side straight to the fetch side. An instruction whose mask is all zeros needs no field beats and becomes an all-no-op word at once.

Top module: `vliw_expander`

## Requirements
- R1: A synchronous active-high `rst` puts the block back in the wait-for-mask state, even partway through an instruction. In the cycle after reset is released, `out_valid` is 0 and `in_ready` is 1.
- R2: The first accepted beat of each instruction is the mask. Mask bit i stands for slot i, which occupies `out_word[32*i+31 : 32*i]`.
- R3: After the mask, the block accepts exactly popcount(mask) more beats as fields. It places them into the occupied slots in ascending slot order: the first field goes to the lowest occupied slot. `out_valid` stays 0 until the last field is accepted and rises on the clock edge that accepts it.
- R4: Every slot whose mask bit is 0 holds 32'h0000_0000, the no-op, in the presented word.
- R5: With an all-zero mask, `out_valid` rises on the clock edge that accepts the mask beat and `out_word` is all zeros. No field beats are consumed.
- R6: While `out_valid` is 1 and `out_ready` is 0, `in_ready` is 0 and `out_word` holds its value.
- R7: When `out_valid` and `out_ready` are both 1 on a clock edge, the word is handed over. On the next cycle `out_valid` is 0, `in_ready` is 1, and the next accepted beat is treated as a new mask.
- R8: A full mask (all 32 bits set) takes 32 field beats and fills every slot from them.
- R9: Cycles with `in_valid` low, in either the mask or the field phase, change nothing. The result is the same as for a stream with no gaps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Compressed stream beat valid |
| in_ready | output | 1 | Block can accept a beat |
| in_data | input | 32 | Mask beat or packed operation field |
| out_valid | output | 1 | Expanded word available |
| out_ready | input | 1 | Consumer takes the expanded word |
| out_word | output | 1024 | Expanded instruction, slot i at bits [32*i+31:32*i] |

## Verification
The expander is driven with masks that set a single lowest slot, a single highest slot, a single middle slot and a sparse irregular pattern. It also gets a full mask, with field values that differ per beat. The single-slot masks show whether the slot index maps to the right bit position. The sparse and full masks show whether packed fields are taken in ascending order and whether the gaps are filled with no-ops. The all-zero mask, the input gaps and a reset partway through an instruction cover the cases where the field count or the phase could go wrong. A consumer that holds off for several cycles exercises the stall path.

// File: rtl/vexp_pkg.sv
package vexp_pkg;

    typedef enum logic [1:0] {
        VX_MASK  = 2'd0,
        VX_FIELD = 2'd1,
        VX_HOLD  = 2'd2
    } vx_state_e;

endpackage

// File: rtl/vexp_low_pick.sv
// Index of the lowest set bit of a slot-occupancy vector.
module vexp_low_pick #(
    parameter int N  = 32,
    parameter int IW = 5
) (
    input  logic [N-1:0]  vec,
    output logic [IW-1:0] idx
);
    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) idx = IW'(i);
        end
    end
endmodule

// File: rtl/vexp_slot_write.sv
// Replaces one slot of a wide word with a new field; the other slots pass through.
module vexp_slot_write #(
    parameter int SLOT_W    = 32,
    parameter int NUM_SLOTS = 32,
    parameter int IW        = 5
) (
    input  logic [SLOT_W*NUM_SLOTS-1:0] word_in,
    input  logic [IW-1:0]               idx,
    input  logic [SLOT_W-1:0]           field,
    output logic [SLOT_W*NUM_SLOTS-1:0] word_out
);
    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
        assign word_out[s*SLOT_W +: SLOT_W] =
            (idx == IW'(s)) ? field : word_in[s*SLOT_W +: SLOT_W];
    end
endmodule

// File: rtl/vliw_expander.sv
module vliw_expander #(
    parameter int SLOT_W    = 32,
    parameter int NUM_SLOTS = 32
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        in_valid,
    output logic                        in_ready,
    input  logic [SLOT_W-1:0]           in_data,
    output logic                        out_valid,
    input  logic                        out_ready,
    output logic [SLOT_W*NUM_SLOTS-1:0] out_word
);
    import vexp_pkg::*;

    localparam int WORD_W = SLOT_W * NUM_SLOTS;
    localparam int IW     = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1;

    typedef struct packed {
        vx_state_e            st;
        logic [NUM_SLOTS-1:0] pend;
        logic [WORD_W-1:0]    word;
    } regs_t;

    regs_t q, d;

    logic [IW-1:0]        slot_idx;
    logic [WORD_W-1:0]    placed_word;
    logic [NUM_SLOTS-1:0] pend_after;
    logic [NUM_SLOTS-1:0] new_mask;
    logic                 fire;

    vexp_low_pick #(.N(NUM_SLOTS), .IW(IW)) pick_i (
        .vec (q.pend),
        .idx (slot_idx)
    );

    vexp_slot_write #(.SLOT_W(SLOT_W), .NUM_SLOTS(NUM_SLOTS), .IW(IW)) place_i (
        .word_in  (q.word),
        .idx      (slot_idx),
        .field    (in_data),
        .word_out (placed_word)
    );

    assign in_ready  = (q.st != VX_HOLD);
    assign out_valid = (q.st == VX_HOLD);
    assign out_word  = q.word;

    always_comb begin
        d          = q;
        fire       = in_valid && in_ready;
        new_mask   = in_data[NUM_SLOTS-1:0];
        pend_after = q.pend & (q.pend - NUM_SLOTS'(1));
        case (q.st)
            VX_MASK: begin
                if (fire) begin
                    d.pend = new_mask;
                    d.word = '0;
                    d.st   = (new_mask == '0) ? VX_HOLD : VX_FIELD;
                end
            end
            VX_FIELD: begin
                if (fire) begin
                    d.word = placed_word;
                    d.pend = pend_after;
                    if (pend_after == '0) d.st = VX_HOLD;
                end
            end
            VX_HOLD: begin
                if (out_ready) d.st = VX_MASK;
            end
            default: d.st = VX_MASK;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q.st   <= VX_MASK;
            q.pend <= '0;
            q.word <= '0;
        end else begin
            q <= d;
        end
    end
endmodule

// File: rtl/vliw_expander_chk.sv
module vliw_expander_chk #(
    parameter int SLOT_W    = 32,
    parameter int NUM_SLOTS = 32
) (
    input logic                        clk,
    input logic                        rst,
    input logic                        in_valid,
    input logic                        in_ready,
    input logic [SLOT_W-1:0]           in_data,
    input logic                        out_valid,
    input logic                        out_ready,
    input logic [SLOT_W*NUM_SLOTS-1:0] out_word
);
    localparam int WORD_W = SLOT_W * NUM_SLOTS;
    localparam int BW     = $clog2(NUM_SLOTS + 1);

    logic                 ck_at_mask_q;
    logic [NUM_SLOTS-1:0] ck_mask_q;
    logic [BW-1:0]        ck_beats_q;
    logic [WORD_W-1:0]    absent_bits;
    logic                 in_fire;

    assign in_fire = in_valid && in_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            ck_at_mask_q <= 1'b1;
            ck_mask_q    <= '0;
            ck_beats_q   <= '0;
        end else begin
            if (in_fire && ck_at_mask_q) begin
                ck_at_mask_q <= 1'b0;
                ck_mask_q    <= in_data[NUM_SLOTS-1:0];
                ck_beats_q   <= '0;
            end else if (in_fire) begin
                ck_beats_q <= ck_beats_q + BW'(1);
            end
            if (out_valid && out_ready) ck_at_mask_q <= 1'b1;
        end
    end

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_abs
        assign absent_bits[s*SLOT_W +: SLOT_W] = {SLOT_W{~ck_mask_q[s]}};
    end

    p_beat_count_r3: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (ck_beats_q == BW'($countones(ck_mask_q))));

    p_noop_fill_r4: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> ((out_word & absent_bits) == '0));

    p_empty_mask_r5: assert property (@(posedge clk) disable iff (rst)
        (in_fire && ck_at_mask_q && (in_data[NUM_SLOTS-1:0] == '0))
        |=> (out_valid && (out_word == '0)));

    p_hold_stall_r6: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> !in_ready);

    p_hold_stable_r6: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_word)));

    p_release_r7: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_ready) |=> (!out_valid && in_ready));
endmodule

bind vliw_expander vliw_expander_chk #(.SLOT_W(SLOT_W), .NUM_SLOTS(NUM_SLOTS)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (in_data),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_word  (out_word)
);

// File: tb/vliw_expander_tb_top.sv
module vliw_expander_tb_top;
    localparam int SW = 32;
    localparam int NS = 32;
    localparam int WW = SW * NS;
    localparam int NVEC = 6;
    localparam logic [31:0] STEP = 32'h0001_0101;

    localparam logic [31:0] VEC_MASK [NVEC] = '{
        32'h0000_0001, 32'h8000_0000, 32'hA5A5_0F0F,
        32'hFFFF_FFFF, 32'h0001_0000, 32'h0000_000C };
    localparam logic [31:0] VEC_SEED [NVEC] = '{
        32'h1111_0001, 32'h2222_0002, 32'h3333_0003,
        32'h4444_0004, 32'h5555_0005, 32'h6666_0006 };
    localparam int VEC_GAP [NVEC] = '{0, 1, 0, 0, 2, 3};

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic [SW-1:0] in_data = '0;
    logic          out_valid;
    logic          out_ready = 1'b0;
    logic [WW-1:0] out_word;

    int errs = 0;
    int checks = 0;

    always #5 clk = ~clk;

    vliw_expander #(.SLOT_W(SW), .NUM_SLOTS(NS)) dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
        .out_word(out_word)
    );

    task automatic check(input bit ok, input string req,
                         input logic [WW-1:0] act, input logic [WW-1:0] exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [WW-1:0] expected_word(input logic [31:0] m,
                                                    input logic [31:0] seed);
        logic [WW-1:0] w = '0;
        logic [31:0]   k = 0;
        for (int i = 0; i < NS; i++) begin
            if (m[i]) begin
                w[i*SW +: SW] = seed + k * STEP;
                k++;
            end
        end
        return w;
    endfunction

    // called at a negedge; returns at the negedge after the accepting edge
    task automatic push(input logic [31:0] d);
        logic acc;
        in_valid = 1'b1;
        in_data  = d;
        do begin
            acc = in_ready;
            @(negedge clk);
        end while (!acc);
        in_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic send_instr(input logic [31:0] m, input logic [31:0] seed,
                              input int gap, input string req);
        logic [WW-1:0] exp_w;
        logic [WW-1:0] held;
        logic [31:0]   k = 0;
        exp_w = expected_word(m, seed);
        push(m);
        if (m != 0) begin
            check(out_valid == 1'b0, {req, " R3 no output before fields"},
                  WW'(out_valid), '0);
            for (int i = 0; i < NS; i++) begin
                if (m[i]) begin
                    idle(gap);
                    push(seed + k * STEP);
                    k++;
                end
            end
        end
        check(out_valid == 1'b1, {req, " R3/R5 valid after last beat"},
              WW'(out_valid), WW'(1));
        check(out_word === exp_w, {req, " R2/R4 expanded word"}, out_word, exp_w);
        held = out_word;
        idle(3);
        check(out_valid && !in_ready, {req, " R6 stall while held"},
              WW'({out_valid, in_ready}), WW'(2'b10));
        check(out_word === held, {req, " R6 word stable"}, out_word, held);
        out_ready = 1'b1;
        @(negedge clk);
        out_ready = 1'b0;
        check(!out_valid && in_ready, {req, " R7 released"},
              WW'({out_valid, in_ready}), WW'(2'b01));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errs++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        idle(3);
        rst = 1'b0;
        @(negedge clk);
        check(!out_valid && in_ready, "R1 reset state",
              WW'({out_valid, in_ready}), WW'(2'b01));

        // table walk: R2 R3 R4 R8 (full mask) R9 (gaps)
        for (int v = 0; v < NVEC; v++) begin
            send_instr(VEC_MASK[v], VEC_SEED[v], VEC_GAP[v],
                       (VEC_MASK[v] == 32'hFFFF_FFFF) ? "R8 full" : "R2 table");
        end

        // R5: empty mask, then the next beat must be a mask again (R7)
        send_instr(32'h0, 32'h0, 0, "R5 empty");
        send_instr(32'h0000_0006, 32'h7777_0007, 0, "R7 mask after empty");

        // R9: idle cycles before the mask beat
        idle(4);
        check(!out_valid && in_ready, "R9 idle keeps waiting",
              WW'({out_valid, in_ready}), WW'(2'b01));
        send_instr(32'h4000_0002, 32'h0ABC_0001, 2, "R9 gaps");

        // R1: reset partway through an instruction
        push(32'h0000_000F);
        push(32'hDEAD_0001);
        rst = 1'b1;
        idle(2);
        rst = 1'b0;
        @(negedge clk);
        check(!out_valid && in_ready, "R1 reset mid instruction",
              WW'({out_valid, in_ready}), WW'(2'b01));
        send_instr(32'h0000_0003, 32'h0BEE_0001, 0, "R1 recover");

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule